// File: doc/BRIEF.md
# Register-Indirect Address Generator

This block forms the memory address for the register-indirect operand modes of a small processor. It also produces the new value of the pointer register. Each request carries:

- the mode, the operand size and the 32-bit pointer register value;
- a displacement;
- a flag saying whether this access is the store half of a read-modify-write.

One cycle after a request strobe the block presents four results: the address, a register write-back value with its enable, and a fault flag.

Every address is wrapped into the memory by an AND with a mask equal to the memory size minus one. The memory size is a configuration input that is captured while reset is held. A size that is not a power of two falls back to the largest supported memory. A 16-bit addressing configuration forces the mask to 0xFFFF. Instruction decode, the register file and the memory access itself stay with the surrounding pipeline.

Top module: `ptr_agu`

## Requirements
- R1: Encodings. Mode 2 is post-increment. The address is the register AND the mask, and the write-back value is that address plus the step. The step is 1, 2 or 4 for size codes 0 (byte), 1 (word) and 2 (long). The write-back enable is set.
- R2: Mode 3 is post-decrement. The address is the register AND the mask, and the write-back value is that address minus the step, wrapping in 32 bits. The write-back enable is set.
- R3: Mode 1 is pre-increment. The register plus the step, ANDed with the mask, is both the address and the write-back value. The write-back enable is set.
- R4: When the read-modify-write second-access flag is set, pre-increment adds no step: the masked register value is both the address and the write-back value. The flag has no effect on any other mode.
- R5: Mode 4 is displacement. The address is (register + displacement) AND the mask, and the write-back enable is clear.
- R6: Mode 0 is plain indirect. The address is the register AND the mask, and the write-back enable is clear.
- R7: The following requests raise the fault output with address 0 and the write-back enable clear:
  - mode 5 (memory indirect);
  - mode 6 or mode 7 (undefined);
  - size code 3.
- R8: The mask is the configured memory size minus one, captured during reset. Changing the size input after reset has no effect.
- R9: A configured size that is zero, not a power of two, or larger than 2^24 selects the mask 0x00FFFFFF.
- R10: When the 16-bit addressing input is high during reset, the mask is 0x0000FFFF whatever size is configured.
- R11: Results appear one clock after the edge that samples the request strobe, with the valid output high for that single cycle. Without a strobe, the valid, write-back enable and fault outputs are 0.
- R12: While reset is active, all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration captured while low |
| cfg_mem_size | input | 32 | Memory size in bytes |
| cfg_narrow | input | 1 | 16-bit addressing configuration |
| in_valid | input | 1 | Request strobe |
| in_mode | input | 3 | Addressing mode code |
| in_size | input | 2 | Operand size code |
| in_rmw_second | input | 1 | Store half of a read-modify-write |
| in_reg | input | 32 | Pointer register value |
| in_disp | input | 32 | Displacement |
| out_valid | output | 1 | Result valid pulse |
| out_addr | output | 32 | Masked effective address |
| out_wb_en | output | 1 | Pointer register write-back enable |
| out_wb_data | output | 32 | Pointer register write-back value |
| out_fault | output | 1 | Unsupported mode or size |

## Verification
The only internal state is the captured mask, plus the result registers that one request fills. A wrong mask shows up at once: the very first result after reset carries high address bits that should have been cleared, or lacks low bits that should remain.

A wrong step or a wrong pre-step decision appears one cycle after the strobe, in the difference between the write-back value and the address. A stale result register is caught on the following idle cycle, through a valid, write-back enable or fault output that stays high.

// File: rtl/ptr_agu_pkg.sv
// Shared encodings for the pointer address generator.
// Assumes the mode and size codes listed in the brief; unused codes are faults.
package ptr_agu_pkg;
    typedef enum logic [2:0] {
        AM_PLAIN   = 3'd0,
        AM_PREINC  = 3'd1,
        AM_POSTINC = 3'd2,
        AM_POSTDEC = 3'd3,
        AM_DISP    = 3'd4,
        AM_MEMIND  = 3'd5
    } amode_e;

    typedef enum logic [1:0] {
        OS_BYTE = 2'd0,
        OS_WORD = 2'd1,
        OS_LONG = 2'd2,
        OS_RSVD = 2'd3
    } osize_e;
endpackage

// File: rtl/ptr_agu_mask_cfg.sv
// Captures the address mask while reset is held low.
// Assumes MAX_LOG2 < AW. An invalid size falls back to the largest memory;
// the narrow configuration forces a 16-bit mask.
module ptr_agu_mask_cfg #(
    parameter int AW       = 32,
    parameter int MAX_LOG2 = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cfg_size,
    input  logic          cfg_narrow,
    output logic [AW-1:0] mask_o
);
    localparam logic [AW-1:0] MAX_MASK    = AW'((64'd1 << MAX_LOG2) - 64'd1);
    localparam logic [AW-1:0] MAX_SIZE    = AW'(64'd1 << MAX_LOG2);
    localparam logic [AW-1:0] NARROW_MASK = AW'(17'h0FFFF);

    logic          size_ok;
    logic [AW-1:0] mask_d;

    // Validate the configured size: nonzero, one bit set, within range.
    always_comb begin
        size_ok = (cfg_size != '0) && ((cfg_size & (cfg_size - AW'(1))) == '0)
                  && (cfg_size <= MAX_SIZE);
    end

    // Choose the mask that reset will capture.
    always_comb begin
        if (cfg_narrow)   mask_d = NARROW_MASK;
        else if (size_ok) mask_d = cfg_size - AW'(1);
        else              mask_d = MAX_MASK;
    end

    // Load the mask only while reset is active; hold it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_o <= mask_d;
    end

    // R9: a captured mask is always one less than a power of two.
    a_r9_mask_pow2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({1'b0, mask_o} + {{AW{1'b0}}, 1'b1}) == 1);
endmodule

// File: rtl/ptr_agu_step.sv
// Maps the operand size code to the pointer step.
// Assumes size code 3 is reserved and reports it as not legal.
module ptr_agu_step #(
    parameter int AW = 32
) (
    input  logic [1:0]    size_i,
    output logic [AW-1:0] step_o,
    output logic          legal_o
);
    import ptr_agu_pkg::*;

    // Decode the size code into a byte count of 1, 2 or 4.
    always_comb begin
        legal_o = 1'b1;
        unique case (osize_e'(size_i))
            OS_BYTE: step_o = AW'(1);
            OS_WORD: step_o = AW'(2);
            OS_LONG: step_o = AW'(4);
            default: begin
                step_o  = '0;
                legal_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/ptr_agu_calc.sv
// Combinational address and write-back computation for one request.
// Assumes the mask and step are supplied by the neighbouring modules.
module ptr_agu_calc #(
    parameter int AW = 32
) (
    input  logic [2:0]    mode_i,
    input  logic          rmw_second_i,
    input  logic [AW-1:0] reg_i,
    input  logic [AW-1:0] disp_i,
    input  logic [AW-1:0] mask_i,
    input  logic [AW-1:0] step_i,
    input  logic          size_legal_i,
    output logic [AW-1:0] addr_o,
    output logic          wb_en_o,
    output logic [AW-1:0] wb_data_o,
    output logic          fault_o
);
    import ptr_agu_pkg::*;

    logic [AW-1:0] masked_reg;
    logic [AW-1:0] pre_val;

    // Shared terms: the wrapped register and the pre-stepped pointer.
    always_comb begin
        masked_reg = reg_i & mask_i;
        pre_val    = (rmw_second_i ? reg_i : reg_i + step_i) & mask_i;
    end

    // Select the address and write-back per mode; anything else faults.
    always_comb begin
        addr_o    = '0;
        wb_en_o   = 1'b0;
        wb_data_o = '0;
        fault_o   = 1'b0;
        if (!size_legal_i) begin
            fault_o = 1'b1;
        end else begin
            case (mode_i)
                AM_PLAIN: addr_o = masked_reg;
                AM_PREINC: begin
                    addr_o    = pre_val;
                    wb_en_o   = 1'b1;
                    wb_data_o = pre_val;
                end
                AM_POSTINC: begin
                    addr_o    = masked_reg;
                    wb_en_o   = 1'b1;
                    wb_data_o = masked_reg + step_i;
                end
                AM_POSTDEC: begin
                    addr_o    = masked_reg;
                    wb_en_o   = 1'b1;
                    wb_data_o = masked_reg - step_i;
                end
                AM_DISP: addr_o = (reg_i + disp_i) & mask_i;
                default: fault_o = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/ptr_agu.sv
// Register-indirect address generator top level.
// Registers one request per strobe; results are valid for one cycle after it.
// Assumes the configuration inputs are stable while reset is held.
module ptr_agu #(
    parameter int AW       = 32,
    parameter int MAX_LOG2 = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cfg_mem_size,
    input  logic          cfg_narrow,
    input  logic          in_valid,
    input  logic [2:0]    in_mode,
    input  logic [1:0]    in_size,
    input  logic          in_rmw_second,
    input  logic [AW-1:0] in_reg,
    input  logic [AW-1:0] in_disp,
    output logic          out_valid,
    output logic [AW-1:0] out_addr,
    output logic          out_wb_en,
    output logic [AW-1:0] out_wb_data,
    output logic          out_fault
);
    import ptr_agu_pkg::*;

    logic [AW-1:0] mask_q;
    logic [AW-1:0] step;
    logic          size_legal;
    logic [AW-1:0] c_addr;
    logic          c_wb_en;
    logic [AW-1:0] c_wb_data;
    logic          c_fault;

    ptr_agu_mask_cfg #(.AW(AW), .MAX_LOG2(MAX_LOG2)) u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_size   (cfg_mem_size),
        .cfg_narrow (cfg_narrow),
        .mask_o     (mask_q)
    );

    ptr_agu_step #(.AW(AW)) u_step (
        .size_i  (in_size),
        .step_o  (step),
        .legal_o (size_legal)
    );

    ptr_agu_calc #(.AW(AW)) u_calc (
        .mode_i       (in_mode),
        .rmw_second_i (in_rmw_second),
        .reg_i        (in_reg),
        .disp_i       (in_disp),
        .mask_i       (mask_q),
        .step_i       (step),
        .size_legal_i (size_legal),
        .addr_o       (c_addr),
        .wb_en_o      (c_wb_en),
        .wb_data_o    (c_wb_data),
        .fault_o      (c_fault)
    );

    // Result register: load on a strobe, drop the pulse flags otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_addr    <= '0;
            out_wb_en   <= 1'b0;
            out_wb_data <= '0;
            out_fault   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_wb_en <= in_valid & c_wb_en;
            out_fault <= in_valid & c_fault;
            if (in_valid) begin
                out_addr    <= c_addr;
                out_wb_data <= c_wb_data;
            end
        end
    end

    // R7: a faulting result never requests a register write.
    a_r7_fault_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault |-> (!out_wb_en && out_addr == '0));

    // R8: every produced address lies inside the captured mask.
    a_r8_addr_within_mask: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_addr & ~mask_q) == '0));

    // R11: a result pulse follows exactly one strobe.
    a_r11_valid_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r11_no_result_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_wb_en && !out_fault));

    // R1: a post-increment result differs from its address by one legal step.
    a_r1_post_step: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == AM_POSTINC && size_legal) |=>
        ($countones(out_wb_data - out_addr) == 1 && (out_wb_data - out_addr) <= AW'(4)));
endmodule

// File: tb/ptr_agu_bench.sv
module ptr_agu_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_mem_size = 32'h0010_0000;
    logic        cfg_narrow = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_mode = '0;
    logic [1:0]  in_size = '0;
    logic        in_rmw_second = 1'b0;
    logic [31:0] in_reg = '0;
    logic [31:0] in_disp = '0;
    logic        out_valid;
    logic [31:0] out_addr;
    logic        out_wb_en;
    logic [31:0] out_wb_data;
    logic        out_fault;

    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptr_agu u_ptr_agu (
        .clk(clk), .rst_n(rst_n), .cfg_mem_size(cfg_mem_size), .cfg_narrow(cfg_narrow),
        .in_valid(in_valid), .in_mode(in_mode), .in_size(in_size),
        .in_rmw_second(in_rmw_second), .in_reg(in_reg), .in_disp(in_disp),
        .out_valid(out_valid), .out_addr(out_addr), .out_wb_en(out_wb_en),
        .out_wb_data(out_wb_data), .out_fault(out_fault)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  mode;
        logic [1:0]  size;
        logic        rmw;
        logic [31:0] rv;
        logic [31:0] dv;
        logic        flt;
        logic [31:0] addr;
        logic        wbe;
        logic [31:0] wb;
    } vec_t;

    // Mask for this table is 0x000FFFFF (size 1 MiB captured in reset).
    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{4'd6, 3'd0, 2'd2, 1'b0, 32'h1234_5678, 32'h0, 1'b0, 32'h0004_5678, 1'b0, 32'h0},          // R6
        '{4'd3, 3'd1, 2'd0, 1'b0, 32'h0000_1000, 32'h0, 1'b0, 32'h0000_1001, 1'b1, 32'h0000_1001}, // R3
        '{4'd3, 3'd1, 2'd2, 1'b0, 32'h00FF_FFFE, 32'h0, 1'b0, 32'h0000_0002, 1'b1, 32'h0000_0002}, // R3
        '{4'd4, 3'd1, 2'd1, 1'b1, 32'h0030_0010, 32'h0, 1'b0, 32'h0000_0010, 1'b1, 32'h0000_0010}, // R4
        '{4'd1, 3'd2, 2'd1, 1'b0, 32'h0050_00FE, 32'h0, 1'b0, 32'h0000_00FE, 1'b1, 32'h0000_0100}, // R1
        '{4'd4, 3'd2, 2'd2, 1'b1, 32'h0000_0100, 32'h0, 1'b0, 32'h0000_0100, 1'b1, 32'h0000_0104}, // R4
        '{4'd2, 3'd3, 2'd0, 1'b0, 32'h0000_0000, 32'h0, 1'b0, 32'h0000_0000, 1'b1, 32'hFFFF_FFFF}, // R2
        '{4'd2, 3'd3, 2'd2, 1'b0, 32'h0020_0008, 32'h0, 1'b0, 32'h0000_0008, 1'b1, 32'h0000_0004}, // R2
        '{4'd5, 3'd4, 2'd1, 1'b0, 32'h0000_1000, 32'hFFFF_FFF0, 1'b0, 32'h0000_0FF0, 1'b0, 32'h0}, // R5
        '{4'd5, 3'd4, 2'd0, 1'b0, 32'h000F_FFFF, 32'h0000_0002, 1'b0, 32'h0000_0001, 1'b0, 32'h0}, // R5
        '{4'd7, 3'd5, 2'd2, 1'b0, 32'h0000_1234, 32'h0, 1'b1, 32'h0, 1'b0, 32'h0},                 // R7
        '{4'd7, 3'd7, 2'd0, 1'b0, 32'h0000_1234, 32'h0, 1'b1, 32'h0, 1'b0, 32'h0},                 // R7
        '{4'd7, 3'd2, 2'd3, 1'b0, 32'h0000_1234, 32'h0, 1'b1, 32'h0, 1'b0, 32'h0},                 // R7
        '{4'd4, 3'd0, 2'd1, 1'b1, 32'h0012_3456, 32'h0, 1'b0, 32'h0002_3456, 1'b0, 32'h0}          // R4
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one request at a negedge; sample the result one negedge later.
    task automatic issue(input logic [2:0] m, input logic [1:0] s, input logic r,
                         input logic [31:0] rv, input logic [31:0] dv);
        @(negedge clk);
        in_valid = 1'b1; in_mode = m; in_size = s; in_rmw_second = r;
        in_reg = rv; in_disp = dv;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_reset(input logic [31:0] sz, input logic nar);
        @(negedge clk);
        rst_n = 1'b0; cfg_mem_size = sz; cfg_narrow = nar;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (2) @(negedge clk);
        // R12: outputs zero while reset is active
        check("R12 valid", {31'b0, out_valid}, 32'h0);
        check("R12 addr", out_addr, 32'h0);
        check("R12 wb_en/fault", {30'b0, out_wb_en, out_fault}, 32'h0);
        rst_n = 1'b1;
        // R8: size changes after reset must not alter the mask
        cfg_mem_size = 32'h0000_1000;

        for (int i = 0; i < NV; i++) begin
            string t;
            t = $sformatf("R%0d vec%0d", VEC[i].req, i);
            issue(VEC[i].mode, VEC[i].size, VEC[i].rmw, VEC[i].rv, VEC[i].dv);
            check({t, " valid"}, {31'b0, out_valid}, 32'h1);
            check({t, " fault"}, {31'b0, out_fault}, {31'b0, VEC[i].flt});
            check({t, " addr"}, out_addr, VEC[i].addr);
            check({t, " wb_en"}, {31'b0, out_wb_en}, {31'b0, VEC[i].wbe});
            if (VEC[i].wbe) check({t, " wb_data"}, out_wb_data, VEC[i].wb);
        end

        // R11: no strobe gives no pulse
        @(negedge clk);
        check("R11 idle valid", {31'b0, out_valid}, 32'h0);
        check("R11 idle wb_en/fault", {30'b0, out_wb_en, out_fault}, 32'h0);

        // R8: the mask stays 0x000FFFFF despite the changed size input
        issue(3'd0, 2'd0, 1'b0, 32'hFFFF_FFFF, 32'h0);
        check("R8 mask held", out_addr, 32'h000F_FFFF);

        // R9: size not a power of two falls back to the 2^24 memory
        do_reset(32'h0003_0000, 1'b0);
        issue(3'd0, 2'd0, 1'b0, 32'hFFFF_FFFF, 32'h0);
        check("R9 non-pow2", out_addr, 32'h00FF_FFFF);
        do_reset(32'h0000_0000, 1'b0);
        issue(3'd0, 2'd2, 1'b0, 32'hFFFF_FFFF, 32'h0);
        check("R9 zero size", out_addr, 32'h00FF_FFFF);
        do_reset(32'h0200_0000, 1'b0);
        issue(3'd0, 2'd2, 1'b0, 32'hFFFF_FFFF, 32'h0);
        check("R9 oversize", out_addr, 32'h00FF_FFFF);

        // R8: a smaller valid size, exercised through post-increment
        do_reset(32'h0000_0100, 1'b0);
        issue(3'd2, 2'd2, 1'b0, 32'h0000_01FE, 32'h0);
        check("R8 small addr", out_addr, 32'h0000_00FE);
        check("R1 small wb", out_wb_data, 32'h0000_0102);

        // R10: narrow configuration forces a 16-bit mask
        do_reset(32'h0010_0000, 1'b1);
        issue(3'd4, 2'd1, 1'b0, 32'h0001_FFF0, 32'h0000_0020);
        check("R10 narrow disp", out_addr, 32'h0000_0010);
        issue(3'd1, 2'd1, 1'b0, 32'h0000_FFFF, 32'h0);
        check("R10 narrow preinc", out_addr, 32'h0000_0001);

        // R11: back-to-back strobes each produce a result
        @(negedge clk);
        in_valid = 1'b1; in_mode = 3'd0; in_size = 2'd0; in_rmw_second = 1'b0;
        in_reg = 32'h0000_0011;
        @(negedge clk);
        check("R11 b2b first", out_addr, 32'h0000_0011);
        in_reg = 32'h0000_0022;
        @(negedge clk);
        in_valid = 1'b0;
        check("R11 b2b second", out_addr, 32'h0000_0022);
        check("R11 b2b valid", {31'b0, out_valid}, 32'h1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule